// File: doc/BRIEF.md
# Burst Address Counter with Load and Clear

This block produces the word address for one port of a memory array. A single cycle with the address strobe low places an externally supplied address in the counter. After that, holding the count enable low moves the address forward by one word on every rising clock edge. The port can then read or write a run of consecutive words without presenting a new address each cycle. Releasing the count enable suspends the run, and the counter keeps its value. A counter clear input sets the address back to zero.

The counter is as wide as the array's address, set by `ADDR_W`, so it covers the whole array. Stepping past the last word returns it to address zero. Every control is sampled only at the rising clock edge. When controls are asserted together, clear wins over load, and load wins over increment. The active-low power-on reset is the only asynchronous input, and it sets the address to zero.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it is released with no control asserted, `burst_addr` is 0.
- R2: A rising edge with `strobe_n`=0 and `clear_n`=1 makes `burst_addr` equal to the `ext_addr` sampled at that edge.
- R3: A rising edge with `count_en_n`=0, `strobe_n`=1 and `clear_n`=1 makes `burst_addr` one greater than its previous value.
- R4: A rising edge with `count_en_n`=1, `strobe_n`=1 and `clear_n`=1 leaves `burst_addr` unchanged.
- R5: A rising edge with `clear_n`=0 makes `burst_addr` equal to 0.
- R6: Incrementing from the all-ones address (2^ADDR_W-1) gives 0, and the following increment gives 1.
- R7: When `clear_n`=0, the levels of `strobe_n`, `count_en_n` and `ext_addr` have no effect. The result is 0.
- R8: When `strobe_n`=0 and `count_en_n`=0 at the same edge (with `clear_n`=1), the result is `ext_addr` itself and not `ext_addr`+1.
- R9: A pulse on `clear_n`, `strobe_n` or `count_en_n` that starts and ends between two rising edges has no effect on `burst_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock. All controls are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low power-on reset. Sets the address to zero |
| ext_addr | input | ADDR_W | Address loaded on a strobe cycle |
| strobe_n | input | 1 | Active-low address strobe (load) |
| count_en_n | input | 1 | Active-low count enable (advance one word) |
| clear_n | input | 1 | Active-low synchronous counter clear |
| burst_addr | output | ADDR_W | Current internal word address |

## Verification
The assertions check every clock edge after reset against the previous cycle's controls:
- a clear gives zero;
- a strobe gives the sampled address;
- an enabled count gives the old address plus one, with the carry out of the top bit yielding zero;
- an idle edge keeps the value;
- at most one decoded operation is active at a time.

Some behaviours can be shown only by the bench's scenarios:
- pulses that never reach a rising edge do nothing;
- a long burst crosses the all-ones boundary and continues from zero;
- reset asserted in the middle of a run returns the output to zero.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_INC   = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } burst_op_e;

  // Fixed precedence: clear, then load, then increment, else hold.
  function automatic burst_op_e pick_op(input logic clr_n,
                                        input logic stb_n,
                                        input logic cnt_n);
    burst_op_e op;
    if (!clr_n)      op = OP_CLEAR;
    else if (!stb_n) op = OP_LOAD;
    else if (!cnt_n) op = OP_INC;
    else             op = OP_HOLD;
    return op;
  endfunction

endpackage

// File: rtl/burst_ctl_decode.sv
module burst_ctl_decode
  import burst_pkg::*;
(
  input  logic      strobe_n,
  input  logic      count_en_n,
  input  logic      clear_n,
  output burst_op_e op_o,
  output logic      sel_clr_o,
  output logic      sel_ld_o,
  output logic      sel_inc_o
);

  always_comb begin
    op_o      = pick_op(clear_n, strobe_n, count_en_n);
    sel_clr_o = (op_o == OP_CLEAR);
    sel_ld_o  = (op_o == OP_LOAD);
    sel_inc_o = (op_o == OP_INC);
  end

endmodule

// File: rtl/burst_incr.sv
module burst_incr #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] a_i,
  output logic [ADDR_W-1:0] sum_o,
  output logic              carry_o
);

  logic [ADDR_W:0] carry;

  assign carry[0] = 1'b1;

  // One half-adder stage per address bit. The final carry marks the wrap.
  for (genvar i = 0; i < ADDR_W; i++) begin : g_stage
    assign sum_o[i]   = a_i[i] ^ carry[i];
    assign carry[i+1] = a_i[i] & carry[i];
  end

  assign carry_o = carry[ADDR_W];

endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_clr_i,
  input  logic              sel_ld_i,
  input  logic              sel_inc_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic [ADDR_W-1:0] inc_val_i,
  output logic [ADDR_W-1:0] q_o
);

  localparam logic [ADDR_W-1:0] ZERO = '0;

  logic [ADDR_W-1:0] d;

  always_comb begin
    d = q_o;
    if (sel_clr_i)      d = ZERO;
    else if (sel_ld_i)  d = load_val_i;
    else if (sel_inc_i) d = inc_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= ZERO;
    else        q_o <= d;
  end

  AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_clr_i, sel_ld_i, sel_inc_i})); // R7

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              strobe_n,
  input  logic              count_en_n,
  input  logic              clear_n,
  output logic [ADDR_W-1:0] burst_addr
);

  localparam logic [ADDR_W-1:0] ONE      = {{(ADDR_W-1){1'b0}}, 1'b1};
  localparam logic [ADDR_W-1:0] ALL_ONES = '1;

  burst_op_e         op;
  logic              sel_clr, sel_ld, sel_inc;
  logic [ADDR_W-1:0] inc_val;
  logic              wrap_evt;

  burst_ctl_decode u_dec (
    .strobe_n   (strobe_n),
    .count_en_n (count_en_n),
    .clear_n    (clear_n),
    .op_o       (op),
    .sel_clr_o  (sel_clr),
    .sel_ld_o   (sel_ld),
    .sel_inc_o  (sel_inc)
  );

  burst_incr #(.ADDR_W(ADDR_W)) u_inc (
    .a_i     (burst_addr),
    .sum_o   (inc_val),
    .carry_o (wrap_evt)
  );

  burst_addr_reg #(.ADDR_W(ADDR_W)) u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_clr_i  (sel_clr),
    .sel_ld_i   (sel_ld),
    .sel_inc_i  (sel_inc),
    .load_val_i (ext_addr),
    .inc_val_i  (inc_val),
    .q_o        (burst_addr)
  );

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n |=> burst_addr == '0); // R5

  AST_LOAD_TAKES_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && !strobe_n) |=> burst_addr == $past(ext_addr)); // R2

  AST_INC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && strobe_n && !count_en_n) |=> burst_addr == $past(burst_addr) + ONE); // R3

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && strobe_n && count_en_n) |=> $stable(burst_addr)); // R4

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_INC && wrap_evt) |=> burst_addr == '0); // R6

  AST_WRAP_ONLY_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |-> burst_addr == ALL_ONES); // R6

endmodule

// File: tb/tb_burst_addr_gen.sv
`timescale 1ns/1ps
module tb_burst_addr_gen;

  localparam int AW   = 16;
  localparam int SPAN = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic          strobe_n = 1'b1;
  logic          count_en_n = 1'b1;
  logic          clear_n = 1'b1;
  logic [AW-1:0] burst_addr;

  int checks = 0;
  int errors = 0;
  int model  = 0;

  always #2 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_addr   (ext_addr),
    .strobe_n   (strobe_n),
    .count_en_n (count_en_n),
    .clear_n    (clear_n),
    .burst_addr (burst_addr)
  );

  task automatic check(input string req, input int exp);
    checks++;
    if (int'(burst_addr) != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, burst_addr, exp[AW-1:0]);
    end
  endtask

  // One clock: drive at the falling edge, apply the model at the rising edge,
  // compare at the next falling edge.
  task automatic cyc(input logic c_n, input logic s_n, input logic e_n,
                     input int a, input string req);
    clear_n = c_n; strobe_n = s_n; count_en_n = e_n; ext_addr = a[AW-1:0];
    @(posedge clk);
    if (!c_n)      model = 0;
    else if (!s_n) model = a % SPAN;
    else if (!e_n) model = (model + 1) % SPAN;
    @(negedge clk);
    check(req, model);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lfsr = 16'hACE1;
    @(negedge clk);
    check("R1", 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cyc(1, 1, 1, 16'h5555, "R1");

    cyc(1, 0, 1, 16'h1234, "R2");
    for (int i = 0; i < 5; i++) cyc(1, 1, 0, 16'h9999, "R3");
    for (int i = 0; i < 3; i++) cyc(1, 1, 1, 16'h0F0F, "R4");
    cyc(1, 1, 0, 0, "R3");
    cyc(0, 1, 1, 16'h4321, "R5");
    cyc(1, 0, 1, 16'hFFFE, "R2");
    cyc(1, 1, 0, 0, "R6");
    cyc(1, 1, 0, 0, "R6");
    cyc(1, 1, 0, 0, "R6");
    cyc(1, 0, 1, 16'h0100, "R2");
    cyc(0, 0, 0, 16'hBEEF, "R7");
    cyc(1, 0, 1, 16'h0200, "R2");
    cyc(0, 1, 0, 16'hBEEF, "R7");
    cyc(1, 0, 0, 16'h7FFF, "R8");
    cyc(1, 0, 0, 16'hFFFF, "R8");

    // R9: short pulses that begin and end between rising edges
    cyc(1, 0, 1, 16'h3000, "R2");
    clear_n = 1'b0; #0.5; clear_n = 1'b1;
    strobe_n = 1'b0; ext_addr = 16'h00AA; #0.5; strobe_n = 1'b1;
    count_en_n = 1'b0; #0.5; count_en_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R9", model);

    // Mixed patterns against the model
    for (int i = 0; i < 300; i++) begin
      lfsr = ((lfsr << 1) | (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1)) & 16'hFFFF;
      cyc((lfsr[3:0] != 0), (lfsr[7:5] != 0), lfsr[8], lfsr, "R2_R3_R4_R5");
    end

    // Long burst across the top of the array
    cyc(1, 0, 1, 16'hFFF0, "R2");
    for (int i = 0; i < 40; i++) cyc(1, 1, 0, 0, "R6");

    // Reset in the middle of a run
    @(negedge clk) rst_n = 1'b0;
    model = 0;
    #1 check("R1", 0);
    @(negedge clk) rst_n = 1'b1;
    cyc(1, 1, 1, 0, "R1");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule